// File: doc/BRIEF.md
# Transmit Lane Bus Framing Monitor

This block watches a multi-lane transmit client bus without driving it. Each beat carries W lanes of 64 bits. Each lane has its own start, end, idle and error marks and a 3-bit empty count. The monitor follows packet boundaries across lanes and beats, and it works out the byte length of every packet. Any framing rule that is broken raises a sticky flag and bumps a per-type event counter. Payload bytes and error marks pass through unexamined.

The bus uses valid/ready semantics with the MAC as the consumer. The MAC request input acts as the ready/valid strobe. A beat counts as transferred only in a cycle where that request is high. While the request is low, the MAC applies back-pressure and every bus field is ignored. The monitor itself never stalls the bus and has no ready output of its own. A synchronous clear input wipes the flags and counters, and it leaves the packet-tracking state untouched.

Top module: `txbus_mon`

## Requirements
- R1: Within a sampled beat, lanes are processed from the highest lane (W-1) down to lane 0. Lane i occupies `lane_data[64*i +: 64]` and bit i of each control vector. `in_pkt` shows whether a packet is open after the last sampled beat.
- R2: Bus fields are sampled only when `mac_req` is 1. While `mac_req` is 0, `in_pkt`, the flags and the counters hold.
- R3: A non-idle lane whose start bit is set while a packet is already open sets framing flag bit 0. A new packet then begins at that lane.
- R4: A non-idle lane whose end bit is set while no packet is open, and which has no start bit of its own, sets framing flag bit 0.
- R5: A nonzero 3-bit empty field (`lane_empty[3*i +: 3]`) on a lane whose end bit is clear sets empty-misuse flag bit 1.
- R6: A lane marked idle while a packet is open, or marked idle while it carries a start or end bit, sets idle-misuse flag bit 2. An idle lane adds no length and does not change the packet state.
- R7: Packet length is 8 bytes per non-idle lane from the start lane through the end lane, minus the empty count of the end lane. A length below 9 bytes sets short-frame flag bit 3, so exactly 9 bytes is legal.
- R8: Flags stay set until `clr` is pulsed. `clr` clears all flags and counters on the next edge, and an event in the same cycle as `clr` is dropped.
- R9: Counter k (`err_cnt[k*CNT_W +: CNT_W]`, k as the flag bit) rises by one per sampled beat in which type k occurs, and it saturates at its maximum.
- R10: After reset, `in_pkt`, `err_flags` and `err_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of flags and counters |
| mac_req | input | 1 | Beat transfer strobe from the MAC |
| lane_data | input | 64*W | Payload lanes, not inspected |
| lane_start | input | W | Per-lane start-of-packet mark |
| lane_end | input | W | Per-lane end-of-packet mark |
| lane_empty | input | 3*W | Per-lane unused byte count |
| lane_idle | input | W | Per-lane idle mark |
| lane_err | input | W | Per-lane error mark, not inspected |
| in_pkt | output | 1 | Packet open after last sampled beat |
| err_flags | output | 4 | Sticky flags: framing, empty, idle, short |
| err_cnt | output | 4*CNT_W | Per-type saturating beat counters |

## Verification
On every cycle, the assertions check the following: a flag never drops without a clear, a clear empties everything, counters never go down, state holds while the request is low, and an end mark outside a packet or an idle lane inside one leads to its flag. Only the directed scenarios can show the actual length arithmetic, the 8-versus-9 byte boundary, the lane processing order inside a beat, and counter saturation. Each of these depends on a specific sequence of beats and on exact expected values.

// File: rtl/txbus_mon_pkg.sv
package txbus_mon_pkg;
  localparam int LANE_BITS = 64;
  localparam int EMPTY_W   = 3;
  localparam int NUM_EV    = 4;
  localparam int LANE_BYTES = LANE_BITS / 8;
  localparam int MIN_LEN   = 9;

  typedef struct packed {
    logic short_f;
    logic idle_f;
    logic empty_f;
    logic frame_f;
  } ev_t;
endpackage

// File: rtl/txbus_lane_step.sv
module txbus_lane_step
  import txbus_mon_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               open_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               start_b,
  input  logic               end_b,
  input  logic [EMPTY_W-1:0] empty_b,
  input  logic               idle_b,
  output logic               open_o,
  output logic [LEN_W-1:0]   len_o,
  output ev_t                ev_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] STEP    = LEN_W'(LANE_BYTES);
  localparam logic [LEN_W-1:0] MINL    = LEN_W'(MIN_LEN);

  logic [LEN_W-1:0] grown;

  always_comb begin
    open_o = open_i;
    len_o  = len_i;
    ev_o   = '0;
    grown  = '0;
    // R5: empty count only legal on the end lane
    if (empty_b != '0 && !end_b) ev_o.empty_f = 1'b1;
    if (idle_b) begin
      // R6: idle lane inside a packet or carrying a boundary mark
      if (open_i || start_b || end_b) ev_o.idle_f = 1'b1;
    end else begin
      if (start_b) begin
        if (open_i) ev_o.frame_f = 1'b1;  // R3
        open_o = 1'b1;
        len_o  = '0;
      end
      if (open_o) begin
        grown = (len_o > LEN_MAX - STEP) ? LEN_MAX : len_o + STEP;
        len_o = grown;
        if (end_b) begin
          len_o = grown - LEN_W'(empty_b);
          if (len_o < MINL) ev_o.short_f = 1'b1;  // R7
          open_o = 1'b0;
        end
      end else if (end_b) begin
        ev_o.frame_f = 1'b1;  // R4
      end
    end
  end
endmodule

// File: rtl/txbus_err_accum.sv
module txbus_err_accum
  import txbus_mon_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic [NUM_EV-1:0]       hit,
  output logic [NUM_EV-1:0]       flags,
  output logic [NUM_EV*CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar k = 0; k < NUM_EV; k++) begin : g_ev
    logic             flag_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        flag_q <= 1'b0;
        cnt_q  <= '0;
      end else if (hit[k]) begin
        flag_q <= 1'b1;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end

    assign flags[k]              = flag_q;
    assign cnt[k*CNT_W +: CNT_W] = cnt_q;

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flags[k] && !clr |=> flags[k]);
    a_r9_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> cnt[k*CNT_W +: CNT_W] >= $past(cnt[k*CNT_W +: CNT_W]));
  end

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flags == '0) && (cnt == '0));
endmodule

// File: rtl/txbus_mon.sv
module txbus_mon
  import txbus_mon_pkg::*;
#(
  parameter int W     = 2,
  parameter int CNT_W = 8,
  parameter int LEN_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    mac_req,
  input  logic [W*LANE_BITS-1:0]  lane_data,
  input  logic [W-1:0]            lane_start,
  input  logic [W-1:0]            lane_end,
  input  logic [W*EMPTY_W-1:0]    lane_empty,
  input  logic [W-1:0]            lane_idle,
  input  logic [W-1:0]            lane_err,
  output logic                    in_pkt,
  output logic [NUM_EV-1:0]       err_flags,
  output logic [NUM_EV*CNT_W-1:0] err_cnt
);
  logic             open_q;
  logic [LEN_W-1:0] len_q;

  logic             open_c [0:W];
  logic [LEN_W-1:0] len_c  [0:W];
  logic [NUM_EV-1:0] ev_lane [0:W-1];
  logic [NUM_EV-1:0] ev_beat;

  // payload and error marks are carried but not checked
  logic unused_fields;
  assign unused_fields = ^{lane_data, lane_err};

  assign open_c[0] = open_q;
  assign len_c[0]  = len_q;

  // R1: stage s handles lane W-1-s, highest lane first
  for (genvar s = 0; s < W; s++) begin : g_stage
    localparam int L = W - 1 - s;
    ev_t ev_s;
    txbus_lane_step #(.LEN_W(LEN_W)) u_step (
      .open_i  (open_c[s]),
      .len_i   (len_c[s]),
      .start_b (lane_start[L]),
      .end_b   (lane_end[L]),
      .empty_b (lane_empty[EMPTY_W*L +: EMPTY_W]),
      .idle_b  (lane_idle[L]),
      .open_o  (open_c[s+1]),
      .len_o   (len_c[s+1]),
      .ev_o    (ev_s)
    );
    assign ev_lane[s] = ev_s;
  end

  always_comb begin
    ev_beat = '0;
    for (int s = 0; s < W; s++) ev_beat = ev_beat | ev_lane[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      len_q  <= '0;
    end else if (mac_req) begin
      open_q <= open_c[W];
      len_q  <= len_c[W];
    end
  end

  assign in_pkt = open_q;

  txbus_err_accum #(.CNT_W(CNT_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .hit   (mac_req ? ev_beat : '0),
    .flags (err_flags),
    .cnt   (err_cnt)
  );

  a_r2_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mac_req |=> $stable(in_pkt));
  a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mac_req && !clr |=> $stable(err_flags));
  a_r4_end_outside: assert property (@(posedge clk) disable iff (!rst_n)
    mac_req && !clr && !in_pkt && lane_end[W-1] && !lane_start[W-1]
      && !lane_idle[W-1] |=> err_flags[0]);
  a_r6_idle_inside: assert property (@(posedge clk) disable iff (!rst_n)
    mac_req && !clr && in_pkt && lane_idle[W-1] |=> err_flags[2]);
endmodule

// File: tb/sim_txbus_mon.sv
module sim_txbus_mon;
  localparam int W = 2;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic mac_req = 1'b0;
  logic [W*64-1:0] lane_data = '0;
  logic [W-1:0] lane_start = '0, lane_end = '0, lane_idle = '0, lane_err = '0;
  logic [W*3-1:0] lane_empty = '0;
  logic in_pkt;
  logic [3:0] err_flags;
  logic [4*CW-1:0] err_cnt;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  txbus_mon #(.W(W), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mac_req(mac_req),
    .lane_data(lane_data), .lane_start(lane_start), .lane_end(lane_end),
    .lane_empty(lane_empty), .lane_idle(lane_idle), .lane_err(lane_err),
    .in_pkt(in_pkt), .err_flags(err_flags), .err_cnt(err_cnt));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic beat(input logic [1:0] s, input logic [1:0] e, input logic [5:0] em,
                      input logic [1:0] id, input logic rq, input logic cl);
    @(negedge clk);
    lane_start = s; lane_end = e; lane_empty = em; lane_idle = id;
    mac_req = rq; clr = cl;
    lane_data = {$urandom, $urandom, $urandom, $urandom};
    lane_err = 2'b11;
    @(posedge clk);
    @(negedge clk);
    lane_start = '0; lane_end = '0; lane_empty = '0; lane_idle = '0;
    mac_req = 1'b0; clr = 1'b0; lane_err = '0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 in_pkt", {31'd0, in_pkt}, 0);
    check("R10 flags", {28'd0, err_flags}, 0);
    check("R10 cnt", err_cnt, 0);
  endtask

  task automatic t_good_packets();
    do_reset();
    beat(2'b10, 2'b00, 6'o00, 2'b00, 1, 0);
    check("R1 open after start", {31'd0, in_pkt}, 1);
    beat(2'b00, 2'b00, 6'o00, 2'b00, 1, 0);
    beat(2'b00, 2'b01, 6'o03, 2'b00, 1, 0);   // 45 bytes
    check("R1 closed after end", {31'd0, in_pkt}, 0);
    check("R7 long packet no flag", {28'd0, err_flags}, 0);
    beat(2'b10, 2'b01, 6'o07, 2'b00, 1, 0);   // exactly 9 bytes
    check("R7 nine bytes legal", {28'd0, err_flags}, 0);
  endtask

  task automatic t_short();
    do_reset();
    beat(2'b10, 2'b10, 6'o00, 2'b00, 1, 0);   // 8 bytes
    check("R7 short flag", {28'd0, err_flags}, 4'b1000);
    check("R9 short count", {24'd0, err_cnt[3*CW +: CW]}, 1);
    check("R7 closed", {31'd0, in_pkt}, 0);
  endtask

  task automatic t_framing();
    do_reset();
    beat(2'b10, 2'b00, 6'o00, 2'b00, 1, 0);
    beat(2'b10, 2'b00, 6'o00, 2'b00, 1, 0);
    check("R3 start inside", {28'd0, err_flags}, 4'b0001);
    check("R3 still open", {31'd0, in_pkt}, 1);
    beat(2'b00, 2'b10, 6'o00, 2'b00, 1, 1);   // clr dominates
    check("R8 clear wins", {28'd0, err_flags}, 0);
    check("R8 counts cleared", err_cnt, 0);
    beat(2'b00, 2'b01, 6'o00, 2'b00, 1, 0);   // end outside
    check("R4 end outside", {28'd0, err_flags}, 4'b0001);
    beat(2'b10, 2'b01, 6'o00, 2'b00, 1, 0);   // clean 16-byte packet
    check("R8 flag sticky", {28'd0, err_flags}, 4'b0001);
    check("R9 framing count", {24'd0, err_cnt[0 +: CW]}, 1);
  endtask

  task automatic t_lane_order();
    do_reset();
    beat(2'b01, 2'b10, 6'o00, 2'b00, 1, 0);
    check("R1 upper lane first flags", {28'd0, err_flags}, 4'b0001);
    check("R1 upper lane first open", {31'd0, in_pkt}, 1);
  endtask

  task automatic t_empty_idle();
    do_reset();
    beat(2'b10, 2'b00, 6'o20, 2'b00, 1, 0);   // lane1 empty=2, no end
    check("R5 empty misuse", {28'd0, err_flags}, 4'b0010);
    beat(2'b00, 2'b01, 6'o00, 2'b10, 1, 0);   // lane1 idle inside
    check("R6 idle inside", {28'd0, err_flags}, 4'b0110);
    check("R6 idle adds no length", {31'd0, in_pkt}, 0);
    do_reset();
    beat(2'b01, 2'b00, 6'o00, 2'b01, 1, 0);   // idle with start
    check("R6 idle with start", {28'd0, err_flags}, 4'b0100);
    check("R6 idle start no open", {31'd0, in_pkt}, 0);
  endtask

  task automatic t_req_low();
    do_reset();
    beat(2'b10, 2'b10, 6'o20, 2'b01, 0, 0);
    check("R2 ignored flags", {28'd0, err_flags}, 0);
    check("R2 ignored state", {31'd0, in_pkt}, 0);
    beat(2'b10, 2'b00, 6'o00, 2'b00, 1, 0);
    beat(2'b00, 2'b10, 6'o00, 2'b00, 0, 0);
    check("R2 open holds", {31'd0, in_pkt}, 1);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 300; i++) beat(2'b10, 2'b00, 6'o00, 2'b00, 1, 0);
    check("R9 saturate", {24'd0, err_cnt[0 +: CW]}, 255);
    check("R9 others zero", {8'd0, err_cnt[CW +: 3*CW]}, 0);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_good_packets();
    t_short();
    t_framing();
    t_lane_order();
    t_empty_idle();
    t_req_low();
    t_saturate();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule